// File: doc/BRIEF.md
# Token Chain Valid-Data Collector

The collector gathers the output words of a row of identical producer nodes into a single output stream. Each node offers a data word and a flag saying the word is meaningful. When a frame is started, the collector freezes a copy of every node's flag and word. A token then moves along the chain from node 0 upward. Nodes whose frozen flag is clear are skipped in the same cycle, so they take no time. Each node whose frozen flag is set sends exactly one word. The word is tagged with that node's index. The frame ends when no flagged node is left, and the collector then gives a one-cycle completion pulse.

The output is a valid/ready stream. While `out_valid` is high and `out_ready` is low, the word on `out_data` stays unchanged and the token does not move. A word is consumed only on a clock edge where both signals are high. While the block is busy, `frame_start` has no effect. A new frame can begin in the cycle that carries the done pulse, or in any later cycle.

Top module: `tc_collector`

## Requirements
- R1: After reset, `busy`, `out_valid` and `frame_done` are 0 and `word_count` is 0.
- R2: A `frame_start` sampled while idle freezes all node flags and words on that edge. Changes to `node_vld` or `node_data` after that edge do not affect the frame.
- R3: Within a frame, words leave in strictly increasing node index. Each node whose frozen flag is set sends exactly once, and no other node sends.
- R4: `out_data` carries the node index in its upper `$clog2(NODES)` bits and that node's frozen word in its lower `DATA_W` bits.
- R5: `out_valid` rises in the cycle after the accepting edge when any flag was frozen set. With `out_ready` held high, one word is consumed on every edge, and cleared nodes cost no cycles.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` stays unchanged on the next cycle. No word is lost or repeated.
- R7: `frame_done` is a one-cycle pulse. It goes high on the second edge after the last word is consumed, or on the second edge after the start for a frame with no flagged node. When it is high, `busy` is low.
- R8: `frame_start` has no effect while `busy` is high.
- R9: `word_count` is cleared when a frame is accepted, rises by one per consumed word, and holds its value after the frame ends.
- R10: `out_valid` is high only while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| node_vld | input | NODES | Per-node data-present flags |
| node_data | input | NODES*DATA_W | Node words, node i at bits [i*DATA_W +: DATA_W] |
| frame_start | input | 1 | Request to begin a frame (taken only when idle) |
| out_valid | output | 1 | Stream word available |
| out_ready | input | 1 | Downstream accepts the word |
| out_data | output | $clog2(NODES)+DATA_W | {node index, node word} |
| busy | output | 1 | Frame in progress |
| frame_done | output | 1 | One-cycle frame-complete pulse |
| word_count | output | $clog2(NODES+1) | Words consumed in the current or last frame |

## Verification
A pending flag that is stuck or cleared in error shows up at the ports. The bench sees a word that is missing, repeated or out of order on the next handshake, and it sees `frame_done` come early or late. A wrong snapshot shows as a mismatch in the tagged word during the first cycle that word is presented. A token that moves while back-pressure is applied changes `out_data` one cycle into the stall. The bench's reference model compares valid, data, done, busy and count on every cycle, so any of these faults is caught within one clock of its appearance.

// File: rtl/tc_pkg.sv
package tc_pkg;
  typedef enum logic {TC_IDLE = 1'b0, TC_RUN = 1'b1} tc_state_e;
endpackage

// File: rtl/tc_snapshot.sv
module tc_snapshot #(
  parameter int NODES  = 8,
  parameter int DATA_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic [NODES-1:0]        node_vld,
  input  logic [NODES*DATA_W-1:0] node_data,
  input  logic [NODES-1:0]        clr_mask,
  output logic [NODES-1:0]        pending,
  output logic [NODES*DATA_W-1:0] words
);
  for (genvar g = 0; g < NODES; g++) begin : g_node
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pending[g] <= 1'b0;
        words[g*DATA_W +: DATA_W] <= '0;
      end else if (load) begin
        pending[g] <= node_vld[g];
        words[g*DATA_W +: DATA_W] <= node_data[g*DATA_W +: DATA_W];
      end else if (clr_mask[g]) begin
        pending[g] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tc_pick.sv
module tc_pick #(
  parameter int NODES = 8,
  localparam int ID_W = $clog2(NODES)
) (
  input  logic [NODES-1:0] pending,
  output logic             any,
  output logic [ID_W-1:0]  idx,
  output logic [NODES-1:0] onehot
);
  always_comb begin
    idx = '0;
    for (int i = NODES - 1; i >= 0; i--) begin
      if (pending[i]) idx = ID_W'(i);
    end
  end
  assign any    = |pending;
  assign onehot = pending & (~pending + NODES'(1));
endmodule

// File: rtl/tc_collector.sv
module tc_collector #(
  parameter int NODES  = 8,
  parameter int DATA_W = 16,
  localparam int ID_W  = $clog2(NODES),
  localparam int OUT_W = ID_W + DATA_W,
  localparam int CNT_W = $clog2(NODES + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NODES-1:0]        node_vld,
  input  logic [NODES*DATA_W-1:0] node_data,
  input  logic                    frame_start,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [OUT_W-1:0]        out_data,
  output logic                    busy,
  output logic                    frame_done,
  output logic [CNT_W-1:0]        word_count
);
  import tc_pkg::*;

  tc_state_e             state;
  logic                  load, fire, any;
  logic [NODES-1:0]      pending, onehot, clr_mask;
  logic [NODES*DATA_W-1:0] words;
  logic [ID_W-1:0]       idx;
  logic [DATA_W-1:0]     sel_word;

  assign load     = frame_start && (state == TC_IDLE);
  assign out_valid = (state == TC_RUN) && any;
  assign fire     = out_valid && out_ready;
  assign clr_mask = onehot & {NODES{fire}};
  assign busy     = (state == TC_RUN);

  tc_snapshot #(.NODES(NODES), .DATA_W(DATA_W)) u_snap (
    .clk(clk), .rst_n(rst_n), .load(load), .node_vld(node_vld),
    .node_data(node_data), .clr_mask(clr_mask), .pending(pending), .words(words)
  );

  tc_pick #(.NODES(NODES)) u_pick (
    .pending(pending), .any(any), .idx(idx), .onehot(onehot)
  );

  always_comb begin
    sel_word = '0;
    for (int i = 0; i < NODES; i++) begin
      if (onehot[i]) sel_word = words[i*DATA_W +: DATA_W];
    end
  end

  assign out_data = {idx, sel_word};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= TC_IDLE;
      frame_done <= 1'b0;
      word_count <= '0;
    end else begin
      frame_done <= (state == TC_RUN) && !any;
      if (load) begin
        state      <= TC_RUN;
        word_count <= '0;
      end else begin
        if ((state == TC_RUN) && !any) state <= TC_IDLE;
        if (fire) word_count <= word_count + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/tc_collector_chk.sv
module tc_collector_chk #(
  parameter int NODES  = 8,
  parameter int DATA_W = 16,
  localparam int ID_W  = $clog2(NODES),
  localparam int OUT_W = ID_W + DATA_W,
  localparam int CNT_W = $clog2(NODES + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frame_start,
  input logic             out_valid,
  input logic             out_ready,
  input logic [OUT_W-1:0] out_data,
  input logic             busy,
  input logic             frame_done,
  input logic [CNT_W-1:0] word_count
);
  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);
  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> !busy && !out_valid);
  // R10
  valid_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> busy);
  // R9
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready |=> word_count == CNT_W'($past(word_count) + 1'b1));
  // R8
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && frame_start && !(out_valid && out_ready) |=> $stable(word_count));
endmodule

bind tc_collector tc_collector_chk #(.NODES(NODES), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .busy(busy),
  .frame_done(frame_done), .word_count(word_count)
);

// File: tb/test_tc_collector.sv
`timescale 1ns/1ps
module test_tc_collector;
  localparam int NODES  = 8;
  localparam int DATA_W = 16;
  localparam int ID_W   = $clog2(NODES);
  localparam int OUT_W  = ID_W + DATA_W;
  localparam int CNT_W  = $clog2(NODES + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NODES-1:0] node_vld = '0;
  logic [NODES*DATA_W-1:0] node_data = '0;
  logic frame_start = 1'b0;
  logic out_ready = 1'b0;
  logic out_valid, busy, frame_done;
  logic [OUT_W-1:0] out_data;
  logic [CNT_W-1:0] word_count;

  always #2.5 clk = ~clk;

  tc_collector #(.NODES(NODES), .DATA_W(DATA_W)) i_tc_collector (
    .clk(clk), .rst_n(rst_n), .node_vld(node_vld), .node_data(node_data),
    .frame_start(frame_start), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .busy(busy), .frame_done(frame_done), .word_count(word_count)
  );

  int n_chk = 0, n_fail = 0;
  bit cmp_en = 0, finished = 0;

  task automatic chk(string tag, bit ok, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference model, behavioural
  logic [OUT_W-1:0] q[$];
  bit m_busy = 0, m_done = 0;
  int m_count = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete(); m_busy = 0; m_done = 0; m_count = 0;
    end else begin
      bit nd;
      nd = m_busy && (q.size() == 0);
      if (m_busy) begin
        if (q.size() == 0) m_busy = 0;
        else if (out_ready) begin void'(q.pop_front()); m_count++; end
      end else if (frame_start) begin
        q.delete();
        for (int i = 0; i < NODES; i++)
          if (node_vld[i]) q.push_back({ID_W'(i), node_data[i*DATA_W +: DATA_W]});
        m_busy = 1; m_count = 0;
      end
      m_done = nd;
    end
  end

  // Per-cycle comparison and stream bookkeeping
  bit prev_v = 0;
  logic [OUT_W-1:0] prev_d = '0;
  int got = 0, last_id = -1;
  always @(negedge clk) begin
    if (rst_n && cmp_en) begin
      bit ev;
      ev = m_busy && (q.size() > 0);
      chk("R5 out_valid", out_valid == ev, out_valid, ev);
      if (ev) chk("R4 out_data", out_data == q[0], out_data, q[0]);
      chk("R7 frame_done", frame_done == m_done, frame_done, m_done);
      chk("R9 word_count", int'(word_count) == m_count, word_count, m_count);
      chk("R10 busy", busy == m_busy, busy, m_busy);
      if (prev_v && !out_ready)
        chk("R6 stall hold", out_valid && out_data == prev_d, out_data, prev_d);
      if (prev_v && out_ready) begin
        int id;
        id = int'(prev_d[OUT_W-1 -: ID_W]);
        chk("R3 order", id > last_id, id, last_id + 1);
        last_id = id;
        got++;
      end
    end
    prev_v = out_valid;
    prev_d = out_data;
  end

  task automatic scramble();
    node_vld = NODES'($urandom);
    for (int i = 0; i < NODES; i++) node_data[i*DATA_W +: DATA_W] = DATA_W'($urandom);
  endtask

  task automatic run_frame(input logic [NODES-1:0] vld, input int rdy_pct,
                           input bit poke, input string tag);
    int expw, cyc;
    bit seen;
    @(negedge clk); #1;
    while (busy || frame_done) begin @(negedge clk); #1; end
    node_vld = vld;
    for (int i = 0; i < NODES; i++) node_data[i*DATA_W +: DATA_W] = DATA_W'($urandom);
    frame_start = 1'b1;
    out_ready = ($urandom % 100) < rdy_pct;
    expw = $countones(vld);
    got = 0; last_id = -1;
    seen = 0; cyc = 0;
    while (!seen && cyc < 300) begin
      @(negedge clk);
      seen = frame_done;
      #1;
      scramble();
      frame_start = poke ? $urandom_range(0, 1) : 1'b0;
      out_ready = ($urandom % 100) < rdy_pct;
      cyc++;
    end
    frame_start = 1'b0;
    chk({tag, " frame ended"}, seen, seen, 1);
    chk({tag, " words per frame"}, got == expw, got, expw);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy", busy == 1'b0, busy, 0);
    chk("R1 out_valid", out_valid == 1'b0, out_valid, 0);
    chk("R1 frame_done", frame_done == 1'b0, frame_done, 0);
    chk("R1 word_count", word_count == '0, word_count, 0);
    #1 rst_n = 1'b1;
    cmp_en = 1;
    run_frame('0, 100, 0, "R5 empty");
    run_frame('1, 100, 0, "R5 full");
    run_frame(8'b1010_0101, 100, 0, "R3 sparse");
    run_frame(8'b1000_0000, 100, 0, "R4 last node");
    run_frame(8'b0000_0001, 30, 0, "R6 single slow");
    run_frame('1, 40, 0, "R6 full stalled");
    run_frame(8'b0110_1100, 100, 1, "R8 start while busy");
    run_frame('1, 50, 1, "R8 stalled with starts");
    for (int k = 0; k < 40; k++)
      run_frame(NODES'($urandom), 20 + ($urandom % 81), k[0], "R2 random snapshot");
    repeat (4) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule